// File: doc/BRIEF.md
# Ring-Oscillator Entropy Collection Controller

This block gathers raw random bits from one external entropy line, such as the output of a free-running ring oscillator. It samples the line once every programmable number of clock cycles and packs the samples into a result of 64, 128, 192 or 256 bits. Software sees the result as eight 32-bit data words. The block does no conditioning and no health testing: it delivers the bit stream as sampled.

Software programs the sample spacing, then writes the control register to pick a length and an oscillator speed, enable the source and set the start bit. It polls the control register until the hardware clears the start bit, and then reads the data words. Every control write carries a per-bit write mask in its upper half-word, so fields can be changed one at a time without a read-modify-write.

Top module: `trng_collect`

## Requirements
- R1: A write to the control register (offset 0x400) changes bit i of its low 16 bits only when write-data bit 16+i is 1. All 16 bits read back as written.
- R2: Setting control bit 0 (start) from 0 to 1 begins a collection. When the last requested bit is captured, the hardware clears start and the data words update in that same cycle.
- R3: Control bits 5:4 select the length: code 0 is 64 bits, 1 is 128, 2 is 192 and 3 is 256. Data words beyond the selected length read as zero after a collection completes.
- R4: The entropy line passes through two flops. With start and enable set and the sample-count register (offset 0x404) at P, the k-th capture (k from 0) occurs P*(k+1) clock edges after the edge that started the run. A sample count of 0 behaves as 1.
- R5: Captured bits fill data word 0 (offset 0x410) first, least significant bit first, then word 1 at 0x414, and so on up to 0x42C.
- R6: While control bit 1 (enable) is 0, start stays set and nothing is captured. Capture timing counts from the edge at which enable is set.
- R7: A control write that clears start aborts the collection. Writing the whole control register to zero stops the source. The data words keep their previous contents until a new collection completes.
- R8: Output osc_speed carries control bits 3:2 and output osc_enable carries control bit 1.
- R9: A write to offset 0x004 with data bit 0 set clears the control register, the data words and the collection state. The sample count is kept.
- R10: bus_ready is always 1 and read data is returned in the same cycle. Unmapped offsets and offset 0x004 read as zero. After reset the control register and data words are zero and the sample count holds SCNT_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| entropy_in | input | 1 | Asynchronous entropy bit |
| osc_speed | output | 2 | Oscillator speed select |
| osc_enable | output | 1 | Entropy source enable |

## Verification
On every cycle the assertions check four things. The data words change only when start falls or on a soft reset. Words beyond the selected length are zero when a collection finishes. The speed output moves only after a control or soft-reset write. A pending start stays set while the source is disabled. Only the bench scenarios can show that each bit was captured at the right edge, through the two-flop delay, and landed in the right bit of the right word. They also show that a zero sample count acts as one and that an aborted run leaves the old result readable.

// File: rtl/trng_collect.sv
module trng_collect #(
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 16,
  parameter int MAX_WORDS = 8,
  parameter int WORD_W    = 32,
  parameter logic [CNT_W-1:0] SCNT_INIT = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  input  logic              entropy_in,
  output logic [1:0]        osc_speed,
  output logic              osc_enable
);
  localparam int MAX_BITS  = MAX_WORDS * WORD_W;
  localparam int BIT_W     = $clog2(MAX_BITS);
  localparam int STEP_BITS = MAX_BITS / 4;
  localparam int STEP_WRDS = MAX_WORDS / 4;
  localparam int WIDX_W    = $clog2(MAX_WORDS);
  localparam logic [ADDR_W-1:0] OFS_SRST = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] OFS_SCNT = ADDR_W'(12'h404);
  localparam logic [ADDR_W-1:0] OFS_DOUT = ADDR_W'(12'h410);

  logic [15:0]         ctrl;
  logic [CNT_W-1:0]    scnt, cnt;
  logic [BIT_W-1:0]    bitcnt;
  logic [MAX_BITS-1:0] acc, acc_nx, dout, keep;
  logic                s1, s2;

  wire start = ctrl[0];
  wire en    = ctrl[1];
  wire [1:0] len = ctrl[5:4];

  wire wr      = bus_valid & bus_write;
  wire wr_ctrl = wr && bus_addr == OFS_CTRL;
  wire wr_scnt = wr && bus_addr == OFS_SCNT;
  wire srst    = wr && bus_addr == OFS_SRST && bus_wdata[0];

  wire [15:0] ctrl_wv = (ctrl & ~bus_wdata[31:16]) | (bus_wdata[15:0] & bus_wdata[31:16]);

  wire [CNT_W-1:0] per_last = (scnt == '0) ? '0 : scnt - 1'b1;
  wire [BIT_W:0]   nbits_m1 = (BIT_W+1)'((int'(len) + 1) * STEP_BITS - 1);
  wire run  = start & en;
  wire cap  = run && cnt == per_last;
  wire last = cap && {1'b0, bitcnt} == nbits_m1;

  assign bus_ready  = 1'b1;
  assign osc_speed  = ctrl[3:2];
  assign osc_enable = ctrl[1];

  always_comb begin
    acc_nx = acc;
    acc_nx[bitcnt] = s2;
  end

  always_comb begin
    for (int i = 0; i < MAX_WORDS; i++)
      keep[i*WORD_W +: WORD_W] = (i < (int'(len) + 1) * STEP_WRDS) ? '1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= entropy_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scnt <= SCNT_INIT;
    else if (wr_scnt) scnt <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      cnt    <= '0;
      bitcnt <= '0;
      acc    <= '0;
      dout   <= '0;
    end else if (srst) begin
      ctrl   <= '0;
      cnt    <= '0;
      bitcnt <= '0;
      dout   <= '0;
    end else begin
      if (run) cnt <= cap ? '0 : cnt + 1'b1;
      if (cap) begin
        acc    <= acc_nx;
        bitcnt <= bitcnt + 1'b1;
      end
      if (last) begin
        ctrl[0] <= 1'b0;
        dout    <= acc_nx & keep;
        bitcnt  <= '0;
      end
      if (wr_ctrl) begin
        ctrl <= ctrl_wv;
        if (ctrl_wv[0] && !start) begin
          cnt    <= '0;
          bitcnt <= '0;
        end
      end
    end
  end

  wire [ADDR_W-1:0] doff = bus_addr - OFS_DOUT;
  wire [WIDX_W-1:0] widx = doff[2 +: WIDX_W];
  wire dhit = bus_addr >= OFS_DOUT && doff < ADDR_W'(MAX_WORDS * 4) && doff[1:0] == 2'b00;

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      if (bus_addr == OFS_CTRL)      bus_rdata = {16'h0, ctrl};
      else if (bus_addr == OFS_SCNT) bus_rdata = 32'(scnt);
      else if (dhit)                 bus_rdata = 32'(dout[widx*WORD_W +: WORD_W]);
    end
  end

  a_r7_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $fell(ctrl[0]) || $past(srst));

  a_r3_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl[0]) && !$past(wr_ctrl) && !$past(srst) |-> (dout & ~keep) == '0);

  a_r8_speed_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(osc_speed) |-> $past(wr_ctrl) || $past(srst));

  a_r6_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && !ctrl[1] && !wr_ctrl && !srst |=> ctrl[0]);
endmodule

// File: tb/trng_collect_test.sv
module trng_collect_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready;
  logic [31:0] bus_rdata;
  logic entropy_in = 1'b0;
  logic [1:0] osc_speed;
  logic osc_enable;

  int total = 0, bad = 0;
  int unsigned ecount = 0;
  int unsigned seed = 32'h1234_5678;
  int unsigned last_w = 0;
  logic [255:0] prev;

  always #4 clk = ~clk;

  trng_collect uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .entropy_in(entropy_in), .osc_speed(osc_speed),
    .osc_enable(osc_enable)
  );

  function automatic logic pat(int unsigned e);
    logic [31:0] h;
    h = (e * 32'h9E37_79B1) ^ seed;
    h = h ^ (h >> 15);
    h = h * 32'h85EB_CA6B;
    return h[16];
  endfunction

  always @(posedge clk) ecount <= ecount + 1;
  always @(negedge clk) entropy_in <= pat(ecount);

  function automatic logic [255:0] expect_bits(int unsigned w, int unsigned p, int unsigned ln);
    logic [255:0] r = '0;
    int unsigned pp = (p == 0) ? 1 : p;
    for (int unsigned k = 0; k < (ln + 1) * 64; k++)
      r[k] = pat(w + (k + 1) * pp - 3);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    last_w = ecount;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wait_done(string tag);
    logic [31:0] v;
    int n = 0;
    do begin
      rd(12'h400, v);
      n++;
    end while (v[0] && n < 3000);
    check(tag, {31'b0, v[0]}, 32'h0);
  endtask

  task automatic check_words(string tag, logic [255:0] exp);
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(12'h410 + 12'(i * 4), v);
      check(tag, v, exp[i*32 +: 32]);
    end
  endtask

  task automatic collect(string tag, int unsigned p, int unsigned ln, logic [1:0] sp);
    logic [255:0] e;
    wr(12'h404, p);
    wr(12'h400, {16'h003F, 10'h0, 2'(ln), sp, 2'b11});
    e = expect_bits(last_w, p, ln);
    check({tag, " R8 speed"}, {30'b0, osc_speed}, {30'b0, sp});
    wait_done({tag, " R2 start clears"});
    check_words({tag, " R3 R4 R5 data"}, e);
    prev = e;
  endtask

  initial begin
    #(8 * 190000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(42));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(12'h400, v); check("R10 reset ctrl", v, 0);
    rd(12'h404, v); check("R10 reset scnt", v, 100);
    check_words("R10 reset data", '0);
    check("R10 ready", {31'b0, bus_ready}, 1);
    rd(12'h200, v); check("R10 unmapped", v, 0);
    check("R8 reset enable", {31'b0, osc_enable}, 0);

    wr(12'h400, 32'h000C_0008);
    rd(12'h400, v); check("R1 masked speed", v, 32'h0008);
    check("R8 speed out", {30'b0, osc_speed}, 2);
    wr(12'h400, 32'h0000_FFFF);
    rd(12'h400, v); check("R1 zero mask", v, 32'h0008);
    wr(12'h400, 32'hFF00_A500);
    rd(12'h400, v); check("R1 high bits", v, 32'hA508);
    wr(12'h400, 32'hFFFF_0000);
    rd(12'h400, v); check("R7 zero write", v, 0);

    collect("R4 period0", 0, 1, 2'd1);
    rd(12'h404, v); check("R4 scnt zero read", v, 0);
    collect("R4 period1 len3", 1, 3, 2'd3);
    collect("R3 len0", 3, 0, 2'd0);

    for (int it = 0; it < 10; it++) begin
      seed = $urandom;
      collect("rand", $urandom % 5, $urandom % 4, 2'($urandom));
    end

    wr(12'h404, 2);
    wr(12'h400, 32'h003F_0001);
    repeat (30) @(negedge clk);
    rd(12'h400, v); check("R6 start held", {31'b0, v[0]}, 1);
    check_words("R6 nothing captured", prev);
    wr(12'h400, 32'h0002_0002);
    begin
      logic [255:0] e;
      e = expect_bits(last_w, 2, 0);
      wait_done("R6 done after enable");
      check_words("R6 data", e);
      prev = e;
    end

    wr(12'h404, 5);
    wr(12'h400, 32'h003F_0033);
    repeat (20) @(negedge clk);
    wr(12'h400, 32'hFFFF_0000);
    rd(12'h400, v); check("R7 abort ctrl", v, 0);
    check("R7 source off", {31'b0, osc_enable}, 0);
    repeat (300) @(negedge clk);
    check_words("R7 data kept", prev);

    wr(12'h004, 32'h1);
    rd(12'h400, v); check("R9 ctrl cleared", v, 0);
    rd(12'h404, v); check("R9 scnt kept", v, 5);
    check_words("R9 data cleared", '0);
    rd(12'h004, v); check("R10 srst reads zero", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule